// File: doc/BRIEF.md
# Next-PC Selector with Branch and Jump Target Generation

This block decides, in a single combinational pass, which address a 32-bit core fetches from next. It takes the address of the current instruction, the operands that a branch or jump needs, and a small code that names the kind of control flow. It returns the next fetch address, a flag that tells the fetch stage the flow was redirected, and the return address that a call writes to the link register.

Branches are PC-relative. A branch adds a signed word offset to the address of the following instruction. The branch-on-equal kind takes the branch when the two compared operands match. The branch-on-not-equal kind takes it when they differ. A direct jump keeps the upper four bits of the following instruction's address and fills the rest from a 26-bit word index. A register jump uses the register operand as the target, and it raises a flag when that target is not word aligned. A jump with link behaves like a direct jump. The link value is the address after the current instruction. A build-time parameter moves it one instruction further, for cores that execute a delay slot.

Top module: `npc_unit`

## Requirements
- R1: With flow code 0 (sequential), next_pc_o equals pc_i+4 modulo 2^32 and taken_o is 0, even when pc_i is 0xFFFFFFFC.
- R2: With flow code 1 (branch if equal) and cmp_a_i equal to cmp_b_i, taken_o is 1 and next_pc_o is pc_i+4 plus br_off_i sign-extended and multiplied by 4. When the operands differ, taken_o is 0 and next_pc_o is pc_i+4.
- R3: With flow code 2 (branch if not equal), the branch is taken exactly when cmp_a_i differs from cmp_b_i. The target is formed as in R2. When not taken, next_pc_o is pc_i+4.
- R4: A negative branch offset (br_off_i bit 15 set) moves the target backward, and target arithmetic wraps modulo 2^32.
- R5: With flow code 3 (jump), taken_o is 1. Bits 31..28 of next_pc_o are bits 31..28 of pc_i+4, bits 27..2 are jmp_idx_i, and bits 1..0 are 0.
- R6: With flow code 5 (register jump), taken_o is 1 and next_pc_o equals reg_tgt_i unchanged.
- R7: misalign_o is 1 only for flow code 5 when reg_tgt_i bits 1..0 are not both zero. For every other flow code it is 0.
- R8: With flow code 4 (jump with link), next_pc_o and taken_o match flow code 3.
- R9: link_o equals pc_i+4 by default, or pc_i+8 when parameter LINK_PAST_SLOT is 1, for any flow code.
- R10: Flow codes 6 and 7 behave as sequential flow: next_pc_o is pc_i+4, and taken_o and misalign_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| flow_i | input | 3 | Control-flow kind: 0 seq, 1 branch-eq, 2 branch-ne, 3 jump, 4 jump-link, 5 register jump |
| br_off_i | input | 16 | Signed branch offset in instruction words |
| jmp_idx_i | input | 26 | Word index for direct jumps |
| reg_tgt_i | input | 32 | Register operand used as the register-jump target |
| cmp_a_i | input | 32 | First branch comparison operand |
| cmp_b_i | input | 32 | Second branch comparison operand |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Flow redirected away from pc_i+4 |
| link_o | output | 32 | Return address for the link register |
| misalign_o | output | 1 | Register-jump target not word aligned |

## Verification
Each branch kind is driven with matching operands and with operands that differ only in one bit, including the top bit. A comparator that ignores part of the word, or a swapped equal and not-equal sense, is therefore exposed. The offsets used are positive, negative, zero and the extreme values. A current address near the top of memory shows whether sign extension and wrap-around are correct. Jumps are tried from an address whose +4 crosses a 256 MiB region boundary, which separates a region taken from pc_i from one taken from pc_i+4. Register jumps use aligned targets and targets with each low-bit pattern. A second instance with the delay-slot parameter set shows that the link offset follows the parameter.

// File: rtl/npc_pkg.sv
// Shared types for the next-PC selector.
// Assumes a 3-bit flow code. Codes above JREG are treated as sequential flow.
package npc_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JAL  = 3'd4,
        FLOW_JREG = 3'd5
    } flow_e;

endpackage

// File: rtl/npc_cmp.sv
// Operand equality test for conditional branches.
// Assumes both operands have the same width. The output is purely combinational.
module npc_cmp #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             same
);

    logic [WIDTH-1:0] diff_bits;

    // Mark bit positions where the operands disagree.
    always_comb begin
        diff_bits = op_a ^ op_b;
    end

    // Operands match when no bit disagrees.
    always_comb begin
        same = ~|diff_bits;
    end

endmodule

// File: rtl/npc_tgt.sv
// Candidate target generation: the sequential address, the PC-relative branch
// target and the region jump target.
// Assumes instruction size is a power of two and that address bits are split
// into region, index and alignment fields.
module npc_tgt #(
    parameter int XLEN        = 32,
    parameter int OFF_W       = 16,
    parameter int IDX_W       = 26,
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] br_off,
    input  logic [IDX_W-1:0] jmp_idx,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_pc,
    output logic [XLEN-1:0]  jmp_pc
);

    localparam int ALIGN_BITS = $clog2(INSTR_BYTES);
    localparam int EXT_W      = XLEN - OFF_W - ALIGN_BITS;
    localparam int REGION_W   = XLEN - IDX_W - ALIGN_BITS;

    logic [XLEN-1:0] off_bytes;

    // Address of the following instruction.
    always_comb begin
        seq_pc = pc + XLEN'(INSTR_BYTES);
    end

    // Offset scaled to bytes, then sign-extended to full width.
    always_comb begin
        off_bytes = {{EXT_W{br_off[OFF_W-1]}}, br_off, {ALIGN_BITS{1'b0}}};
    end

    // Branch target relative to the following instruction.
    always_comb begin
        br_pc = seq_pc + off_bytes;
    end

    // Region jump: keep the upper bits of the following address.
    always_comb begin
        jmp_pc = {seq_pc[XLEN-1 -: REGION_W], jmp_idx, {ALIGN_BITS{1'b0}}};
    end

endmodule

// File: rtl/npc_link.sv
// Return-address generation. A parameter chooses whether the link skips a
// delay slot.
// Assumes a fixed instruction size.
module npc_link #(
    parameter int XLEN           = 32,
    parameter int INSTR_BYTES    = 4,
    parameter bit LINK_PAST_SLOT = 1'b0
) (
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] link
);

    generate
        if (LINK_PAST_SLOT) begin : g_past_slot
            // Return past the delay-slot instruction.
            always_comb begin
                link = pc + XLEN'(2 * INSTR_BYTES);
            end
        end else begin : g_next_instr
            // Return to the instruction after the call.
            always_comb begin
                link = pc + XLEN'(INSTR_BYTES);
            end
        end
    endgenerate

endmodule

// File: rtl/npc_unit.sv
// Next-PC selector. Chooses the fetch address from the flow code, the branch
// comparison and the candidate targets, and produces the redirect flag, the
// link value and a misaligned register-target flag.
// Assumes a combinational use: all outputs follow the inputs within a cycle.
module npc_unit #(
    parameter int XLEN           = 32,
    parameter int OFF_W          = 16,
    parameter int IDX_W          = 26,
    parameter int INSTR_BYTES    = 4,
    parameter bit LINK_PAST_SLOT = 1'b0
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [2:0]       flow_i,
    input  logic [OFF_W-1:0] br_off_i,
    input  logic [IDX_W-1:0] jmp_idx_i,
    input  logic [XLEN-1:0]  reg_tgt_i,
    input  logic [XLEN-1:0]  cmp_a_i,
    input  logic [XLEN-1:0]  cmp_b_i,
    output logic [XLEN-1:0]  next_pc_o,
    output logic             taken_o,
    output logic [XLEN-1:0]  link_o,
    output logic             misalign_o
);
    import npc_pkg::*;

    localparam int ALIGN_BITS = $clog2(INSTR_BYTES);
    localparam int LINK_STEP  = LINK_PAST_SLOT ? 2 * INSTR_BYTES : INSTR_BYTES;

    flow_e           flow;
    logic            ops_equal;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] jmp_pc;
    logic            br_go;

    npc_cmp #(.WIDTH(XLEN)) u_cmp (
        .op_a (cmp_a_i),
        .op_b (cmp_b_i),
        .same (ops_equal)
    );

    npc_tgt #(
        .XLEN        (XLEN),
        .OFF_W       (OFF_W),
        .IDX_W       (IDX_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_tgt (
        .pc      (pc_i),
        .br_off  (br_off_i),
        .jmp_idx (jmp_idx_i),
        .seq_pc  (seq_pc),
        .br_pc   (br_pc),
        .jmp_pc  (jmp_pc)
    );

    npc_link #(
        .XLEN           (XLEN),
        .INSTR_BYTES    (INSTR_BYTES),
        .LINK_PAST_SLOT (LINK_PAST_SLOT)
    ) u_link (
        .pc   (pc_i),
        .link (link_o)
    );

    // Decode the raw flow code.
    always_comb begin
        flow = flow_e'(flow_i);
    end

    // Branch decision from the comparison sense.
    always_comb begin
        br_go = ((flow == FLOW_BEQ) &&  ops_equal) ||
                ((flow == FLOW_BNE) && !ops_equal);
    end

    // Select the next fetch address and the redirect flag.
    always_comb begin
        next_pc_o = seq_pc;
        taken_o   = 1'b0;
        case (flow)
            FLOW_BEQ, FLOW_BNE: begin
                if (br_go) begin
                    next_pc_o = br_pc;
                    taken_o   = 1'b1;
                end
            end
            FLOW_JMP, FLOW_JAL: begin
                next_pc_o = jmp_pc;
                taken_o   = 1'b1;
            end
            FLOW_JREG: begin
                next_pc_o = reg_tgt_i;
                taken_o   = 1'b1;
            end
            default: begin
                next_pc_o = seq_pc;
                taken_o   = 1'b0;
            end
        endcase
    end

    // Flag a register target that is not instruction aligned.
    always_comb begin
        misalign_o = (flow == FLOW_JREG) && (|reg_tgt_i[ALIGN_BITS-1:0]);
    end

    // Output relations checked against the port values.
    always_comb begin
        if (flow_i == 3'd0) begin
            AST_SEQ_STEP: assert (!taken_o && next_pc_o == pc_i + XLEN'(INSTR_BYTES)); // R1
        end
        if (!taken_o) begin
            AST_FALLTHRU_STEP: assert (next_pc_o == pc_i + XLEN'(INSTR_BYTES)); // R2
        end
        if (flow_i == 3'd3 || flow_i == 3'd4) begin
            AST_JUMP_ALIGNED: assert (taken_o && next_pc_o[ALIGN_BITS-1:0] == '0); // R5
        end
        if (flow_i == 3'd5) begin
            AST_JREG_PASS: assert (taken_o && next_pc_o == reg_tgt_i); // R6
        end
        if (misalign_o) begin
            AST_MISALIGN_SRC: assert (flow_i == 3'd5 && next_pc_o[ALIGN_BITS-1:0] != '0); // R7
        end
        AST_LINK_STEP: assert (link_o - pc_i == XLEN'(LINK_STEP)); // R9
    end

endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [31:0] pc;
    logic [2:0]  flow;
    logic [15:0] off;
    logic [25:0] idx;
    logic [31:0] rtgt;
    logic [31:0] ca;
    logic [31:0] cb;

    logic [31:0] npc, link, link_ds, npc_ds;
    logic        tkn, mis, tkn_ds, mis_ds;

    always #2 clk = ~clk;

    npc_unit i_npc_unit (
        .pc_i(pc), .flow_i(flow), .br_off_i(off), .jmp_idx_i(idx),
        .reg_tgt_i(rtgt), .cmp_a_i(ca), .cmp_b_i(cb),
        .next_pc_o(npc), .taken_o(tkn), .link_o(link), .misalign_o(mis)
    );

    npc_unit #(.LINK_PAST_SLOT(1'b1)) i_npc_unit_ds (
        .pc_i(pc), .flow_i(flow), .br_off_i(off), .jmp_idx_i(idx),
        .reg_tgt_i(rtgt), .cmp_a_i(ca), .cmp_b_i(cb),
        .next_pc_o(npc_ds), .taken_o(tkn_ds), .link_o(link_ds), .misalign_o(mis_ds)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one input set away from the clock edge, then let it settle.
    task automatic apply(input logic [31:0] p, input logic [2:0] f, input logic [15:0] o,
                         input logic [25:0] j, input logic [31:0] r,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        pc = p; flow = f; off = o; idx = j; rtgt = r; ca = a; cb = b;
        #1;
    endtask

    function automatic logic [31:0] br_exp(input logic [31:0] p, input logic [15:0] o);
        return p + 32'd4 + {{14{o[15]}}, o, 2'b00};
    endfunction

    task automatic t_reset_state();
        chk("R1 reset next", npc, 32'h4);
        chk("R1 reset taken", {31'd0, tkn}, 32'd0);
        chk("R9 reset link", link, 32'h4);
        chk("R7 reset misalign", {31'd0, mis}, 32'd0);
    endtask

    task automatic t_sequential();
        apply(32'h0040_0010, 3'd0, 16'h7FFF, 26'h3FF_FFFF, 32'h3, 32'h1, 32'h1);
        chk("R1 seq next", npc, 32'h0040_0014);
        chk("R1 seq taken", {31'd0, tkn}, 32'd0);
        chk("R7 seq no misalign", {31'd0, mis}, 32'd0);
        apply(32'hFFFF_FFFC, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0);
        chk("R1 seq wrap", npc, 32'h0);
    endtask

    task automatic t_branch_eq();
        apply(32'h0000_1000, 3'd1, 16'h0010, 26'h0, 32'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        chk("R2 beq taken next", npc, br_exp(32'h1000, 16'h0010));
        chk("R2 beq taken flag", {31'd0, tkn}, 32'd1);
        apply(32'h0000_1000, 3'd1, 16'h0010, 26'h0, 32'h0, 32'hDEAD_BEEF, 32'h5EAD_BEEF);
        chk("R2 beq top-bit diff next", npc, 32'h0000_1004);
        chk("R2 beq top-bit diff flag", {31'd0, tkn}, 32'd0);
        apply(32'h0000_1000, 3'd1, 16'h0000, 26'h0, 32'h0, 32'h7, 32'h7);
        chk("R2 beq zero offset", npc, 32'h0000_1004);
        chk("R2 beq zero offset flag", {31'd0, tkn}, 32'd1);
    endtask

    task automatic t_branch_ne();
        apply(32'h0000_2000, 3'd2, 16'h0004, 26'h0, 32'h0, 32'h1, 32'h0);
        chk("R3 bne taken next", npc, br_exp(32'h2000, 16'h0004));
        chk("R3 bne taken flag", {31'd0, tkn}, 32'd1);
        apply(32'h0000_2000, 3'd2, 16'h0004, 26'h0, 32'h0, 32'h1234_5678, 32'h1234_5678);
        chk("R3 bne equal next", npc, 32'h0000_2004);
        chk("R3 bne equal flag", {31'd0, tkn}, 32'd0);
    endtask

    task automatic t_branch_range();
        apply(32'h0000_2000, 3'd1, 16'hFFFE, 26'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 backward", npc, 32'h0000_1FFC);
        apply(32'h0000_0010, 3'd1, 16'h8000, 26'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 most negative wrap", npc, br_exp(32'h10, 16'h8000));
        apply(32'hFFFF_FFF0, 3'd2, 16'h7FFF, 26'h0, 32'h0, 32'h1, 32'h2);
        chk("R4 positive wrap", npc, br_exp(32'hFFFF_FFF0, 16'h7FFF));
    endtask

    task automatic t_jump();
        apply(32'h0FFF_FFFC, 3'd3, 16'h0, 26'h000_0040, 32'h0, 32'h0, 32'h0);
        chk("R5 jump region from pc+4", npc, 32'h1000_0100);
        chk("R5 jump flag", {31'd0, tkn}, 32'd1);
        apply(32'hA000_0000, 3'd3, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 32'h0);
        chk("R5 jump full index", npc, 32'hAFFF_FFFC);
        apply(32'hA000_0000, 3'd4, 16'h0, 26'h123_4567, 32'h0, 32'h0, 32'h0);
        chk("R8 jal next", npc, {4'hA, 26'h123_4567, 2'b00});
        chk("R8 jal flag", {31'd0, tkn}, 32'd1);
        chk("R9 jal link", link, 32'hA000_0004);
        chk("R9 jal link slot", link_ds, 32'hA000_0008);
    endtask

    task automatic t_jreg();
        apply(32'h0000_3000, 3'd5, 16'h0, 26'h0, 32'h8000_0040, 32'h0, 32'h0);
        chk("R6 jr next", npc, 32'h8000_0040);
        chk("R6 jr flag", {31'd0, tkn}, 32'd1);
        chk("R7 jr aligned", {31'd0, mis}, 32'd0);
        for (int k = 1; k < 4; k++) begin
            apply(32'h0000_3000, 3'd5, 16'h0, 26'h0, 32'h0000_0100 | 32'(k), 32'h0, 32'h0);
            chk("R6 jr unaligned next", npc, 32'h0000_0100 | 32'(k));
            chk("R7 jr unaligned flag", {31'd0, mis}, 32'd1);
        end
        apply(32'h0000_3000, 3'd3, 16'h0, 26'h0, 32'h3, 32'h0, 32'h0);
        chk("R7 jump ignores reg low bits", {31'd0, mis}, 32'd0);
    endtask

    task automatic t_unused_codes();
        for (int c = 6; c < 8; c++) begin
            apply(32'h0000_4000, 3'(c), 16'h0040, 26'h1, 32'h3, 32'h5, 32'h5);
            chk("R10 unused next", npc, 32'h0000_4004);
            chk("R10 unused taken", {31'd0, tkn}, 32'd0);
            chk("R10 unused misalign", {31'd0, mis}, 32'd0);
        end
    endtask

    task automatic t_link_param();
        apply(32'h0000_5000, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0);
        chk("R9 link default", link, 32'h0000_5004);
        chk("R9 link delay slot", link_ds, 32'h0000_5008);
        chk("R9 slot variant next", npc_ds, 32'h0000_5004);
    endtask

    initial begin
        pc = '0; flow = '0; off = '0; idx = '0; rtgt = '0; ca = '0; cb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_sequential();
        t_branch_eq();
        t_branch_ne();
        t_branch_range();
        t_jump();
        t_jreg();
        t_unused_codes();
        t_link_param();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule